// File: doc/BRIEF.md
# SM4 Block Cipher Round Engine

This block runs the 32 rounds of the SM4 block cipher over one 128-bit block, either encrypting or decrypting it. Round keys are not stored inside. On every cycle the engine publishes the round numbers it is about to consume, one per lane. An external key store answers on `key_rk` in the same cycle. Key expansion is the job of whatever fills that store.

A block enters over a valid/ready handshake together with a direction bit. The engine then folds `ROUNDS_PER_CYCLE` rounds into each clock until all 32 are done, and offers the result over a second valid/ready handshake. Only one block is in flight. The input side stays closed from the cycle after acceptance until the result has been taken. `ROUNDS_PER_CYCLE` must divide 32, so the latency can be traded against combinational depth.

Top module: `sm4_round_engine`

## Requirements
- R1: `rst_n` is a synchronous active-low reset. After it, `out_valid` is 0, `in_ready` is 1 and the internal step counter is zero. A reset in the middle of a block discards that block.
- R2: A block is taken on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 until the result has left. While it is 0, `in_valid`, `in_block` and `in_decrypt` have no effect.
- R3: `out_valid` rises exactly 32/`ROUNDS_PER_CYCLE` clock cycles after the accepting edge.
- R4: Lane k reports its round number on `key_idx[5k+4:5k]` and takes its key from `key_rk[32k+31:32k]`. In processing step s, encryption (`in_decrypt`=0) asks for round s*`ROUNDS_PER_CYCLE`+k. Decryption (`in_decrypt`=1) asks for 31 minus that value.
- R5: `in_block[127:96]` is state word 0 and `in_block[31:0]` is word 3. One round computes w0 ^ T(w1 ^ w2 ^ w3 ^ key). Words 1..3 move down to positions 0..2, and the new value becomes word 3.
- R6: T replaces each byte with the standard SM4 S-box output and then mixes the word B as B ^ rotl(B,2) ^ rotl(B,10) ^ rotl(B,18) ^ rotl(B,24). The S-box is computed, not stored. It applies the affine map y[i] = parity(x & rotl8(0xA7,i)) ^ 0xD3[i], takes the inverse in GF(2^8) modulo x^8+x^7+x^6+x^5+x^4+x^2+1 (zero maps to zero), and applies the same affine map again.
- R7: `out_block` carries the final four state words in reverse order. The newest word is in `out_block[127:96]` and the oldest in `out_block[31:0]`.
- R8: Decryption uses the same datapath with descending key order. Decrypting an encryption result under the same round keys returns the original block.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_valid` and `out_block` hold. The result leaves on the edge where both are 1.
- R10: Use round keys expanded from key 0x0123456789abcdeffedcba9876543210. Encrypting that same value gives 0x681edf34d206965e86b3e94f536e4246, and decrypting this ciphertext gives the value back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Engine can take a block |
| in_decrypt | input | 1 | 1 selects decryption, 0 encryption |
| in_block | input | 128 | Input block, word 0 in the top bits |
| key_idx | output | 5*ROUNDS_PER_CYCLE | Round number requested per lane |
| key_rk | input | 32*ROUNDS_PER_CYCLE | Round key returned per lane |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_block | output | 128 | Result block, newest word in the top bits |

## Verification
A step counter that is out of place shows up at once on `key_idx`, in the cycle after acceptance. It also shifts the moment `out_valid` rises, which the latency check against 32/`ROUNDS_PER_CYCLE` catches. A corrupted state word or a wrong S-box byte stays hidden until the result appears, but the cipher's diffusion then spreads it over the whole block. Known-answer vectors, a bench reference model and encrypt/decrypt round trips each expose it at the first result.

// File: rtl/sm4_round_engine.sv
module sm4_round_engine #(
  parameter int ROUNDS_PER_CYCLE = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  output logic                          in_ready,
  input  logic                          in_decrypt,
  input  logic [127:0]                  in_block,
  output logic [ROUNDS_PER_CYCLE*5-1:0] key_idx,
  input  logic [ROUNDS_PER_CYCLE*32-1:0] key_rk,
  output logic                          out_valid,
  input  logic                          out_ready,
  output logic [127:0]                  out_block
);
  localparam int STEPS = 32 / ROUNDS_PER_CYCLE;
  localparam int CW = (STEPS > 1) ? $clog2(STEPS) : 1;
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  if (ROUNDS_PER_CYCLE < 1 || (32 % ROUNDS_PER_CYCLE) != 0) begin : g_bad_rpc
    $error("ROUNDS_PER_CYCLE must divide 32");
  end

  function automatic logic [7:0] gf_mul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = '0;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p ^= x;
      x = {x[6:0], 1'b0} ^ (x[7] ? 8'hF5 : 8'h00);
    end
    return p;
  endfunction

  function automatic logic [7:0] gf_inv(input logic [7:0] a);
    logic [7:0] r;
    r = a;
    for (int i = 0; i < 6; i++) r = gf_mul(gf_mul(r, r), a);
    return gf_mul(r, r);
  endfunction

  function automatic logic [7:0] affine(input logic [7:0] x);
    logic [7:0] y, m;
    m = 8'hA7;
    for (int i = 0; i < 8; i++) begin
      y[i] = ^(x & m);
      m = {m[6:0], m[7]};
    end
    return y ^ 8'hD3;
  endfunction

  function automatic logic [31:0] tfun(input logic [31:0] w);
    logic [31:0] b;
    for (int i = 0; i < 4; i++) b[8*i +: 8] = affine(gf_inv(affine(w[8*i +: 8])));
    return b ^ {b[29:0], b[31:30]} ^ {b[21:0], b[31:22]} ^ {b[13:0], b[31:14]} ^ {b[7:0], b[31:8]};
  endfunction

  logic          busy, dec_q;
  logic [CW-1:0] cnt;
  logic [127:0]  st, nxt;

  assign in_ready  = !busy && !out_valid;
  assign out_block = {st[31:0], st[63:32], st[95:64], st[127:96]};

  always_comb begin
    for (int k = 0; k < ROUNDS_PER_CYCLE; k++) begin
      int r;
      r = int'(cnt) * ROUNDS_PER_CYCLE + k;
      key_idx[5*k +: 5] = 5'(dec_q ? 31 - r : r);
    end
  end

  always_comb begin
    nxt = st;
    for (int k = 0; k < ROUNDS_PER_CYCLE; k++)
      nxt = {nxt[95:0], nxt[127:96] ^ tfun(nxt[95:64] ^ nxt[63:32] ^ nxt[31:0] ^ key_rk[32*k +: 32])};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      out_valid <= 1'b0;
      dec_q     <= 1'b0;
      cnt       <= '0;
      st        <= '0;
    end else if (in_valid && in_ready) begin
      st    <= in_block;
      dec_q <= in_decrypt;
      busy  <= 1'b1;
      cnt   <= '0;
    end else if (busy) begin
      st <= nxt;
      if (cnt == LAST) begin
        busy      <= 1'b0;
        out_valid <= 1'b1;
        cnt       <= '0;
      end else begin
        cnt <= cnt + CW'(1);
      end
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  logic [6:0] lat_q;
  always_ff @(posedge clk) begin
    if (!rst_n) lat_q <= '0;
    else if (in_valid && in_ready) lat_q <= '0;
    else if (busy) lat_q <= lat_q + 7'd1;
  end

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (!out_valid && !busy && cnt == '0));

  assert_input_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  assert_latency_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid) |-> lat_q == 7'(STEPS));

  assert_last_key_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt == LAST) |-> key_idx[5*(ROUNDS_PER_CYCLE-1) +: 5] == (dec_q ? 5'd0 : 5'd31));

  assert_output_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_block)));
endmodule

// File: tb/tb_sm4_round_engine.sv
`timescale 1ns/1ps
module tb_sm4_round_engine;
  localparam int RPC = 4;
  localparam int STEPS = 32 / RPC;
  localparam int NV = 5;
  localparam logic [127:0] KK = 128'h0123456789abcdeffedcba9876543210;
  localparam logic [127:0] KC = 128'h681edf34d206965e86b3e94f536e4246;
  localparam logic [127:0] VKEY [NV] = '{KK, KK, 128'h000102030405060708090a0b0c0d0e0f,
                                         128'hffeeddccbbaa99887766554433221100, {128{1'b1}}};
  localparam logic [127:0] VIN  [NV] = '{KK, KC, 128'h00112233445566778899aabbccddeeff,
                                         128'h0, {128{1'b1}}};
  localparam logic [127:0] VEXP [NV] = '{KC, KK, 128'h0, 128'h0, 128'h0};
  localparam bit VDEC [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0};
  localparam bit VHAS [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0};

  logic clk = 1'b0;
  logic rst_n, in_valid, in_ready, in_decrypt, out_valid, out_ready;
  logic [127:0] in_block, out_block;
  logic [RPC*5-1:0] key_idx;
  logic [RPC*32-1:0] key_rk;
  logic [31:0] rk_tbl [0:31];
  logic [7:0] sb [0:255];
  int nchk, nerr;

  always #2 clk = ~clk;

  sm4_round_engine #(.ROUNDS_PER_CYCLE(RPC)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_decrypt(in_decrypt), .in_block(in_block), .key_idx(key_idx), .key_rk(key_rk),
    .out_valid(out_valid), .out_ready(out_ready), .out_block(out_block));

  always_comb
    for (int k = 0; k < RPC; k++) key_rk[32*k +: 32] = rk_tbl[key_idx[5*k +: 5]];

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] fmul(input logic [7:0] a, input logic [7:0] b);
    logic [14:0] p;
    p = '0;
    for (int i = 0; i < 8; i++) if (b[i]) p ^= 15'(a) << i;
    for (int i = 14; i >= 8; i--) if (p[i]) p ^= 15'(9'h1F5) << (i - 8);
    return p[7:0];
  endfunction

  function automatic logic [7:0] aff(input logic [7:0] x);
    logic [7:0] cols [8];
    logic [7:0] y;
    cols = '{8'hD3, 8'hE9, 8'hF4, 8'h7A, 8'h3D, 8'h9E, 8'h4F, 8'hA7};
    for (int j = 0; j < 8; j++) y[7-j] = ^(x & cols[j]);
    return y ^ 8'hD3;
  endfunction

  task automatic build_sbox();
    logic [7:0] inv [0:255];
    for (int x = 0; x < 256; x++) begin
      inv[x] = 8'h00;
      for (int y = 1; y < 256; y++) if (fmul(8'(x), 8'(y)) == 8'h01) inv[x] = 8'(y);
    end
    for (int x = 0; x < 256; x++) sb[x] = aff(inv[aff(8'(x))]);
  endtask

  function automatic logic [31:0] subw(input logic [31:0] w);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) r[8*b +: 8] = sb[w[8*b +: 8]];
    return r;
  endfunction

  task automatic set_key(input logic [127:0] mk);
    logic [31:0] kw [0:35];
    kw[0] = mk[127:96] ^ 32'ha3b1bac6;
    kw[1] = mk[95:64]  ^ 32'h56aa3350;
    kw[2] = mk[63:32]  ^ 32'h677d9197;
    kw[3] = mk[31:0]   ^ 32'hb27022dc;
    for (int i = 0; i < 32; i++) begin
      logic [31:0] ck, b;
      for (int j = 0; j < 4; j++) ck[31-8*j -: 8] = 8'((4*i + j) * 7);
      b = subw(kw[i+1] ^ kw[i+2] ^ kw[i+3] ^ ck);
      kw[i+4] = kw[i] ^ b ^ {b[18:0], b[31:19]} ^ {b[8:0], b[31:9]};
      rk_tbl[i] = kw[i+4];
    end
  endtask

  function automatic logic [127:0] model(input logic [127:0] blk, input bit dec);
    logic [31:0] x [4];
    for (int w = 0; w < 4; w++) x[w] = blk[127-32*w -: 32];
    for (int i = 0; i < 32; i++) begin
      logic [31:0] b, n;
      b = subw(x[1] ^ x[2] ^ x[3] ^ rk_tbl[dec ? 31 - i : i]);
      n = x[0] ^ b ^ {b[29:0], b[31:30]} ^ {b[21:0], b[31:22]} ^ {b[13:0], b[31:14]} ^ {b[7:0], b[31:8]};
      x[0] = x[1]; x[1] = x[2]; x[2] = x[3]; x[3] = n;
    end
    return {x[3], x[2], x[1], x[0]};
  endfunction

  task automatic run_block(input logic [127:0] blk, input bit dec, output logic [127:0] res);
    int lat;
    bit idx_ok;
    @(negedge clk);
    check(in_ready == 1'b1, "R2 ready before accept", 128'(in_ready), 128'd1);
    in_valid = 1'b1; in_block = blk; in_decrypt = dec;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    check(in_ready == 1'b0, "R2 ready drops after accept", 128'(in_ready), 128'd0);
    lat = 0; idx_ok = 1'b1;
    while (!out_valid && lat < 64) begin
      for (int k = 0; k < RPC; k++) begin
        int r;
        r = lat * RPC + k;
        if (key_idx[5*k +: 5] != 5'(dec ? 31 - r : r)) idx_ok = 1'b0;
      end
      @(negedge clk);
      lat++;
    end
    check(lat == STEPS, "R3 latency", 128'(lat), 128'(STEPS));
    check(idx_ok, "R4 key index order", 128'(key_idx), 128'(dec));
    res = out_block;
    in_valid = 1'b1; in_block = ~blk; in_decrypt = ~dec;
    repeat (2) @(negedge clk);
    check(out_valid && !in_ready && out_block == res, "R9 R2 hold while stalled", out_block, res);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b0;
    check(!out_valid && in_ready, "R9 R2 result leaves, stray input ignored",
          128'({out_valid, in_ready}), 128'b01);
  endtask

  initial begin
    nchk = 0; nerr = 0;
    rst_n = 1'b0; in_valid = 1'b0; in_decrypt = 1'b0; in_block = '0; out_ready = 1'b0;
    build_sbox();
    for (int i = 0; i < 32; i++) rk_tbl[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 reset state", 128'({out_valid, in_ready}), 128'b01);

    for (int v = 0; v < NV; v++) begin
      logic [127:0] res, back, exp;
      set_key(VKEY[v]);
      exp = VHAS[v] ? VEXP[v] : model(VIN[v], VDEC[v]);
      run_block(VIN[v], VDEC[v], res);
      if (VHAS[v]) check(res == exp, "R6 R10 known answer", res, exp);
      else         check(res == exp, "R5 R7 reference model", res, exp);
      run_block(res, !VDEC[v], back);
      check(back == VIN[v], "R8 round trip", back, VIN[v]);
    end

    set_key(KK);
    @(negedge clk);
    in_valid = 1'b1; in_block = KK; in_decrypt = 1'b0;
    @(negedge clk);
    in_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!out_valid && in_ready, "R1 reset mid-block", 128'({out_valid, in_ready}), 128'b01);
    repeat (STEPS + 2) @(negedge clk);
    check(!out_valid, "R1 discarded block never appears", 128'(out_valid), 128'd0);

    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule